// File: doc/BRIEF.md
# Chien Search Root Finder

This block locates the error positions of a length-255 Reed-Solomon codeword over GF(2^8). It receives the coefficients of an error locator polynomial of degree at most four, together with the locator degree that the upstream solver believes it found, and a single-cycle start pulse. It then sweeps every codeword position, one position per clock, and flags each position at which the locator evaluates to zero.

Evaluation is incremental. One register per coefficient is loaded with the coefficient at start, and every cycle it is multiplied by a fixed power of the primitive element. The multipliers therefore have a constant operand and reduce to XOR networks. An XOR tree adds the registers to give the locator value at the current position. Position k is a root when Λ(α^(-k)) = 0.

The block keeps a running count of roots. When the sweep ends it raises a done pulse, and a mismatch flag if the count disagrees with the supplied degree. The decoder downstream uses that flag to declare the codeword uncorrectable.

Top module: `chien_search`

## Requirements
- R1: After reset, pos_valid, err_flag, done and mismatch are 0 and root_count is 0, and they stay so until a start pulse.
- R2: One cycle after start, pos_valid is 1 with pos_idx 0. pos_idx then rises by one each cycle through 254, so there are 255 consecutive valid cycles.
- R3: Field details:
  - The field is GF(2^8) with reduction polynomial 0x11D and α = 0x02.
  - Coefficient λi sits at coef_in bits [8i+7:8i], for i = 0..4.
  - err_flag is 1 at position k exactly when the XOR over i of λi·α^(-ik) equals 0.
- R4: done is a one-cycle pulse in the cycle after position 254. pos_valid is 0 in that cycle.
- R5: root_count is cleared by start and increases by one for each flagged position. It holds its final value from the done cycle until the next start.
- R6: mismatch is 1 only in the done cycle, and only when root_count differs from the degree_in value captured at start.
- R7: A start during a sweep abandons that sweep. The next cycle shows position 0 for the new coefficients, with root_count cleared and no done pulse for the abandoned sweep.
- R8: err_flag is never 1 while pos_valid is 0.
- R9: Degenerate locators:
  - A locator with only λ0 nonzero yields no roots.
  - An all-zero locator flags all 255 positions, so root_count ends at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads coefficients and degree, and begins a sweep |
| coef_in | input | 40 | Locator coefficients, λi in byte i |
| degree_in | input | 3 | Degree reported by the locator solver |
| pos_valid | output | 1 | A position is being reported this cycle |
| pos_idx | output | 8 | Position under test, 0..254 |
| err_flag | output | 1 | The current position is a locator root |
| done | output | 1 | One-cycle pulse after the last position |
| root_count | output | 8 | Roots found in the current or last sweep |
| mismatch | output | 1 | With done: the root count differs from the degree |

## Verification
The bench builds locators from chosen root sets, including roots at positions 0 and 254 at the two ends of the sweep, and compares every position against a reference evaluation.

Some faults show up at specific corners:
- Using the wrong constant multiplier, or the wrong sign on the exponent, moves roots to mirrored positions.
- An off-by-one in the position counter either drops position 254 or shifts every index.
- Counting the root in the done cycle, or failing to clear the count on start, makes root_count disagree with the number of flags.

The bench also covers these cases:
- The all-zero locator checks that the count reaches 255 without wrapping.
- A deliberately wrong degree checks that mismatch fires.
- A restart mid-sweep checks that a stale done pulse or stale count does not leak through.

// File: rtl/chien_pkg.sv
package chien_pkg;

    localparam int SYM_W = 8;
    localparam int NFIELD = 255;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] gf_t;

    typedef struct packed {
        logic       busy;
        logic [7:0] idx;
        logic       done;
    } sweep_t;

    // Multiply by alpha (x) with reduction
    function automatic gf_t gf_xtime(input gf_t a);
        gf_t r;
        r = {a[SYM_W-2:0], 1'b0};
        if (a[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
        return r;
    endfunction

    // Shift-and-add product; with one constant operand this folds to XORs
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int j = 0; j < SYM_W; j++) begin
            if (b[j]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic gf_t gf_alpha_pow(input int e);
        gf_t r;
        r = gf_t'(1);
        for (int j = 0; j < e; j++) r = gf_xtime(r);
        return r;
    endfunction

endpackage

// File: rtl/chien_term.sv
module chien_term
    import chien_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  gf_t  coef_in,
    output gf_t  term_q
);
    // step factor alpha^(-IDX) written as a nonnegative exponent
    localparam int  STEP_EXP = (NFIELD - (IDX % NFIELD)) % NFIELD;
    localparam gf_t STEP_K   = gf_alpha_pow(STEP_EXP);

    gf_t term_next;

    always_comb begin
        if (IDX == 0) term_next = term_q;
        else          term_next = gf_mul(term_q, STEP_K);
    end

    always_ff @(posedge clk) begin
        if (rst)       term_q <= '0;
        else if (load) term_q <= coef_in;
        else if (step) term_q <= term_next;
    end
endmodule

// File: rtl/chien_xor_tree.sv
module chien_xor_tree
    import chien_pkg::*;
#(
    parameter int NT = 5
) (
    input  logic [NT-1:0][SYM_W-1:0] terms,
    output gf_t                      sum,
    output logic                     is_zero
);
    localparam int LVL = (NT > 1) ? $clog2(NT) : 1;
    localparam int WID = 1 << LVL;

    logic [LVL:0][WID-1:0][SYM_W-1:0] node;

    always_comb begin
        node = '0;
        for (int j = 0; j < NT; j++) node[0][j] = terms[j];
        for (int l = 0; l < LVL; l++) begin
            for (int j = 0; j < (WID >> (l + 1)); j++) begin
                node[l+1][j] = node[l][2*j] ^ node[l][2*j+1];
            end
        end
    end

    assign sum     = node[LVL][0];
    assign is_zero = (node[LVL][0] == '0);
endmodule

// File: rtl/chien_seq.sv
module chien_seq
    import chien_pkg::*;
#(
    parameter int NPOS = 255
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output sweep_t st
);
    localparam logic [7:0] LAST = 8'(NPOS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.done <= 1'b0;
            if (start) begin
                st.busy <= 1'b1;
                st.idx  <= '0;
            end else if (st.busy) begin
                if (st.idx == LAST) begin
                    st.busy <= 1'b0;
                    st.done <= 1'b1;
                end else begin
                    st.idx <= st.idx + 8'd1;
                end
            end
        end
    end
endmodule

// File: rtl/chien_tally.sv
module chien_tally #(
    parameter int CNT_W = 8,
    parameter int DEG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hit,
    input  logic             finish,
    input  logic [DEG_W-1:0] degree_in,
    output logic [CNT_W-1:0] count,
    output logic             mismatch
);
    logic [DEG_W-1:0] deg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            deg_q <= '0;
        end else if (start) begin
            count <= '0;
            deg_q <= degree_in;
        end else if (hit) begin
            count <= count + CNT_W'(1);
        end
    end

    assign mismatch = finish && (count != CNT_W'(deg_q));
endmodule

// File: rtl/chien_search.sv
module chien_search
    import chien_pkg::*;
#(
    parameter int T    = 4,
    parameter int NPOS = 255,
    localparam int NT    = T + 1,
    localparam int IDX_W = 8,
    localparam int CNT_W = $clog2(NPOS + 1),
    localparam int DEG_W = $clog2(T + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NT*SYM_W-1:0]   coef_in,
    input  logic [DEG_W-1:0]      degree_in,
    output logic                  pos_valid,
    output logic [IDX_W-1:0]      pos_idx,
    output logic                  err_flag,
    output logic                  done,
    output logic [CNT_W-1:0]      root_count,
    output logic                  mismatch
);
    sweep_t                    st;
    logic [NT-1:0][SYM_W-1:0]  terms;
    gf_t                       loc_val;
    logic                      loc_zero;
    logic                      advance;

    assign advance = st.busy && !start;

    chien_seq #(.NPOS(NPOS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .st    (st)
    );

    for (genvar g = 0; g < NT; g++) begin : g_term
        chien_term #(.IDX(g)) u_term (
            .clk     (clk),
            .rst     (rst),
            .load    (start),
            .step    (advance),
            .coef_in (coef_in[g*SYM_W +: SYM_W]),
            .term_q  (terms[g])
        );
    end

    chien_xor_tree #(.NT(NT)) u_tree (
        .terms   (terms),
        .sum     (loc_val),
        .is_zero (loc_zero)
    );

    chien_tally #(.CNT_W(CNT_W), .DEG_W(DEG_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hit       (advance && loc_zero),
        .finish    (st.done),
        .degree_in (degree_in),
        .count     (root_count),
        .mismatch  (mismatch)
    );

    assign pos_valid = st.busy;
    assign pos_idx   = st.idx;
    assign err_flag  = st.busy && loc_zero;
    assign done      = st.done;
endmodule

// File: rtl/chien_search_chk.sv
module chien_search_chk #(
    parameter int NPOS = 255
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       pos_valid,
    input logic [7:0] pos_idx,
    input logic       err_flag,
    input logic       done,
    input logic       mismatch
);
    localparam logic [7:0] LAST = 8'(NPOS - 1);

    p_start_pos0_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (pos_valid && pos_idx == 8'd0));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pos_valid && !start && pos_idx != LAST) |=>
            (pos_valid && pos_idx == $past(pos_idx) + 8'd1));

    p_range_r2: assert property (@(posedge clk) disable iff (rst)
        pos_valid |-> (pos_idx <= LAST));

    p_done_after_last_r4: assert property (@(posedge clk) disable iff (rst)
        (pos_valid && !start && pos_idx == LAST) |=> (done && !pos_valid));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_mismatch_only_done_r6: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> done);

    p_restart_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    p_flag_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> pos_valid);
endmodule

bind chien_search chien_search_chk #(.NPOS(NPOS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pos_valid (pos_valid),
    .pos_idx   (pos_idx),
    .err_flag  (err_flag),
    .done      (done),
    .mismatch  (mismatch)
);

// File: tb/sim_chien_search.sv
`timescale 1ns/1ps
module sim_chien_search;
    localparam int T = 4;
    localparam int NPOS = 255;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [39:0] coef_in;
    logic [2:0]  degree_in;
    logic        pos_valid;
    logic [7:0]  pos_idx;
    logic        err_flag;
    logic        done;
    logic [7:0]  root_count;
    logic        mismatch;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    chien_search u0 (
        .clk(clk), .rst(rst), .start(start), .coef_in(coef_in),
        .degree_in(degree_in), .pos_valid(pos_valid), .pos_idx(pos_idx),
        .err_flag(err_flag), .done(done), .root_count(root_count),
        .mismatch(mismatch)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gx(input logic [7:0] a);
        return a[7] ? ({a[6:0], 1'b0} ^ 8'h1D) : {a[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 0;
        logic [7:0] s = a;
        for (int j = 0; j < 8; j++) begin
            if (b[j]) acc ^= s;
            s = gx(s);
        end
        return acc;
    endfunction

    function automatic logic [7:0] apow(input int e);
        logic [7:0] r = 8'h01;
        for (int j = 0; j < e % 255; j++) r = gx(r);
        return r;
    endfunction

    function automatic bit is_root(input logic [39:0] lam, input int k);
        logic [7:0] s = 0;
        for (int i = 0; i <= T; i++) begin
            int e = (i * k) % 255;
            s ^= gmul(lam[8*i +: 8], apow((255 - e) % 255));
        end
        return (s == 0);
    endfunction

    // product of (1 + alpha^r x) over chosen positions, times scale c
    function automatic logic [39:0] build(input int r[4], input int n, input logic [7:0] c);
        logic [7:0] p[5];
        logic [39:0] o;
        p[0] = 8'h01;
        for (int j = 1; j < 5; j++) p[j] = 0;
        for (int m = 0; m < n; m++) begin
            logic [7:0] a = apow(r[m]);
            for (int j = 4; j >= 1; j--) p[j] = p[j] ^ gmul(a, p[j-1]);
        end
        for (int j = 0; j < 5; j++) o[8*j +: 8] = gmul(p[j], c);
        return o;
    endfunction

    task automatic sweep(input logic [39:0] lam, input logic [2:0] deg, input int want_roots);
        int cnt = 0;
        int bad = 0;
        @(negedge clk);
        coef_in = lam; degree_in = deg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        coef_in = '1; degree_in = 3'd7;
        for (int k = 0; k < NPOS; k++) begin
            bit exp_f = is_root(lam, k);
            if (exp_f) cnt++;
            if (!(pos_valid && pos_idx == 8'(k))) begin
                bad++;
                check(0, "R2", "position index", pos_idx, k);
            end
            if (err_flag != exp_f) begin
                bad++;
                check(0, "R3", "err_flag", err_flag, exp_f);
            end
            @(negedge clk);
        end
        check(bad == 0, "R3", "sweep flag errors", bad, 0);
        if (want_roots >= 0) check(cnt == want_roots, "R3", "reference roots", cnt, want_roots);
        check(done == 1'b1, "R4", "done pulse", done, 1);
        check(pos_valid == 1'b0, "R4", "valid low at done", pos_valid, 0);
        check(root_count == 8'(cnt), "R5", "root_count", root_count, cnt);
        check(mismatch == (cnt != int'(deg)), "R6", "mismatch", mismatch, cnt != int'(deg));
        @(negedge clk);
        check(done == 1'b0 && mismatch == 1'b0, "R4", "done one cycle", done, 0);
        check(root_count == 8'(cnt), "R5", "count held", root_count, cnt);
        check(pos_valid == 1'b0 && err_flag == 1'b0, "R8", "idle flag", err_flag, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int r[4];
        void'($urandom(32'd4711));
        rst = 1'b1; start = 1'b0; coef_in = '0; degree_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(pos_valid == 0 && err_flag == 0, "R1", "valid/flag after reset", pos_valid, 0);
        check(done == 0 && mismatch == 0, "R1", "done after reset", done, 0);
        check(root_count == 0, "R1", "count after reset", root_count, 0);

        // boundary roots at both ends of the sweep
        r = '{0, 254, 100, 7};
        sweep(build(r, 4, 8'h01), 3'd4, 4);
        r = '{0, 0, 0, 0};
        sweep(build(r, 1, 8'h53), 3'd1, 1);
        // R9 constant locator and all-zero locator
        sweep(40'h00_0000_0005, 3'd0, 0);
        sweep(40'h0, 3'd0, 255);
        // R6 wrong degree supplied
        r = '{3, 77, 200, 0};
        sweep(build(r, 3, 8'h9A), 3'd2, 3);

        // constrained random root sets
        for (int s = 0; s < 6; s++) begin
            int n = $urandom_range(0, 4);
            logic [7:0] c = 8'($urandom_range(1, 255));
            for (int m = 0; m < n; m++) begin
                bit dup;
                do begin
                    r[m] = $urandom_range(0, 254);
                    dup = 0;
                    for (int q = 0; q < m; q++) if (r[q] == r[m]) dup = 1;
                end while (dup);
            end
            sweep(build(r, n, c), 3'(n), n);
        end
        // arbitrary coefficient sets
        for (int s = 0; s < 2; s++) begin
            logic [39:0] lam = {8'($urandom), $urandom};
            sweep(lam, 3'($urandom_range(0, 4)), -1);
        end

        // R7 restart mid-sweep
        r = '{10, 20, 0, 0};
        @(negedge clk);
        coef_in = 40'h0; degree_in = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(root_count == 8'd20, "R7", "count before restart", root_count, 20);
        sweep(build(r, 2, 8'h11), 3'd2, 2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule